// File: doc/BRIEF.md
# Self-Reset Sequencer

This block is a cycle-level model of the local reset timing chain that a self-resetting dynamic logic macro uses in place of a global clock. It watches a completion signal: the OR of the monitored output rails of the macro. When any of those rails goes active, the macro has evaluated. The sequencer then fires a chain of per-row reset pulses, staggered along the chain. A late tap of the chain clears the trigger, so the pulses end without outside help and the macro returns to standby. A second, independent chain serves the final sum row. It fires when either the true or the complement rail of any sum bit is active, which keeps the sum-row pulses short at the macro edge.

Upstream logic launches one input token at a time and watches a ready output to know when the next launch is allowed. A launch that lands while the main chain is resetting, draining or held sets a sticky error flag.

Three global test inputs override normal operation:
- The inhibit input keeps the macro in its evaluated state.
- The hold input forces every reset output on.
- The static input removes all pulsing, so the datapath behaves as plain static logic.

Each chain is a state machine with the following states:
- STANDBY: idle, no inputs or outputs active.
- EVAL: a token has been accepted, or evaluation is frozen.
- RESET: the chain is running.
- SETTLE: the chain has ended and the block waits for completion to drop.
- HOLD: reset is forced by test.

Each chain moves between states on these transitions:
- LAUNCH: STANDBY to EVAL, on a token.
- FIRE: STANDBY or EVAL to RESET, when completion is seen and reset is not inhibited.
- FREEZE: STANDBY to EVAL, when completion is seen while reset is inhibited.
- END_CLEAN: RESET to STANDBY.
- END_BUSY: RESET to SETTLE.
- DRAIN: SETTLE to STANDBY.
- FORCE: any state to HOLD.
- RELEASE: HOLD to SETTLE.
- FLATTEN: any state to STANDBY, while in static mode.

Top module: `srst_seq_top`

## Requirements
- R1: After rst_n is released, every row and sum reset output is low, ready_o is high and err_o is low. rst_n is the only way to clear err_o.
- R2: A launch_i pulse in standby moves the main chain to EVAL. There, ready_o is low and no reset output is asserted until completion is seen.
- R3: With no test input active, an active monitored line in STANDBY or EVAL fires the main chain. Take c as the number of clock edges after the firing edge (c = 0 in the cycle right after it). Let L be (ROWS-1)*ROW_DLY. Then row_rst_o[k] is high exactly when k*ROW_DLY <= c <= k*ROW_DLY + L.
- R4: The chain ends at c = 2L. If completion is inactive at that edge, the chain returns to STANDBY. Otherwise it waits in SETTLE, with all its reset outputs low and ready_o low, until completion drops.
- R5: The sum chain fires when any bit of sum_t_i or sum_c_i is high. It follows the R3/R4 timing with SUM_TAPS and SUM_DLY, independently of the main chain.
- R6: While tm_eval_i is high, completion does not start either chain. A chain that sees completion instead stays in, or enters, EVAL with all its reset outputs low.
- R7: tm_hold_i has the highest priority. From the next edge on, every row and sum reset output is high and ready_o is low. When the input is released, both chains go to SETTLE.
- R8: When tm_static_i is high and tm_hold_i is low, both chains are in STANDBY from the next edge on. No reset output is asserted, ready_o is high, and launch_i has no effect and sets no error.
- R9: ready_o is high exactly when both chains are in STANDBY. Whenever ready_o is high, no reset output is asserted.
- R10: err_o is set at the edge where launch_i is high while the main chain is in RESET, SETTLE or HOLD. Once set, it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Upstream token launch |
| mon_i | input | MON_W | Monitored output rails of the evaluation rows, active high |
| sum_t_i | input | SUM_W | True rails of the final sum row |
| sum_c_i | input | SUM_W | Complement rails of the final sum row |
| tm_eval_i | input | 1 | Test: inhibit reset |
| tm_hold_i | input | 1 | Test: hold all resets asserted |
| tm_static_i | input | 1 | Test: static, unpulsed operation |
| row_rst_o | output | ROWS | Per-row reset pulses of the main chain |
| sum_rst_o | output | SUM_TAPS | Reset pulses of the sum-row chain |
| ready_o | output | 1 | A new token may be launched |
| err_o | output | 1 | Sticky error: token launched during reset |

## Verification
The bench builds the block with four rows at a tap spacing of two cycles, so the main chain runs thirteen cycles. This short run lets every overlap of taps, and the END_CLEAN and END_BUSY exits, be checked cycle by cycle. The sum chain uses two taps one cycle apart, which puts its three-cycle pulse train and its SETTLE exit into a short vector table. With six monitored lines and four sum bits, the bench can set one true rail, one complement rail and a single high line among several zero lines, and confirm that each one fires its chain.

// File: rtl/srst_pkg.sv
package srst_pkg;

    typedef enum logic [2:0] {
        S_STANDBY,
        S_EVAL,
        S_RESET,
        S_SETTLE,
        S_HOLD
    } chain_st_e;

    // Counter width that holds 0..n and never makes n the all-ones value
    function automatic int unsigned cnt_w(input int unsigned n);
        return $clog2(n + 2);
    endfunction

endpackage

// File: rtl/srst_done_or.sv
// Completion detector: a wide OR over RAILS rails per bit for W bits.
module srst_done_or #(
    parameter int unsigned W     = 8,
    parameter int unsigned RAILS = 1
) (
    input  logic [RAILS*W-1:0] rails_i,
    output logic               done_o
);
    logic [W-1:0] bit_act;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RAILS == 1) begin : g_single
            assign bit_act[i] = rails_i[i];
        end else begin : g_multi
            logic [RAILS-1:0] grp;
            for (genvar r = 0; r < RAILS; r++) begin : g_rail
                assign grp[r] = rails_i[r*W + i];
            end
            assign bit_act[i] = |grp;
        end
    end

    assign done_o = |bit_act;
endmodule

// File: rtl/srst_chain.sv
// One reset timing chain controller: state machine plus chain position counter.
module srst_chain
    import srst_pkg::*;
#(
    parameter int unsigned TAPS = 7,
    parameter int unsigned DLY  = 3,
    parameter int unsigned CW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          done_i,
    input  logic          inhibit_i,
    input  logic          hold_i,
    input  logic          static_i,
    output chain_st_e     st_o,
    output logic [CW-1:0] cnt_o,
    output logic          active_o,
    output logic          held_o
);
    localparam int unsigned SPAN = (TAPS - 1) * DLY;
    localparam logic [CW-1:0] END_C = CW'(2 * SPAN);

    chain_st_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_STANDBY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_STANDBY: begin
                if (done_i && !inhibit_i)      st_d = S_RESET;   // FIRE
                else if (done_i && inhibit_i)  st_d = S_EVAL;    // FREEZE
                else if (launch_i)             st_d = S_EVAL;    // LAUNCH
            end
            S_EVAL: begin
                if (done_i && !inhibit_i)      st_d = S_RESET;   // FIRE
            end
            S_RESET: begin
                if (cnt_q == END_C)
                    st_d = done_i ? S_SETTLE : S_STANDBY;        // END_BUSY / END_CLEAN
            end
            S_SETTLE: begin
                if (!done_i)                   st_d = S_STANDBY; // DRAIN
            end
            S_HOLD: begin
                if (!hold_i)                   st_d = S_SETTLE;  // RELEASE
            end
            default:                           st_d = S_STANDBY;
        endcase
        if (hold_i)        st_d = S_HOLD;     // FORCE
        else if (static_i) st_d = S_STANDBY;  // FLATTEN
        cnt_d = (st_q == S_RESET && st_d == S_RESET) ? cnt_q + 1'b1 : '0;
    end

    // Outputs
    always_comb begin
        st_o     = st_q;
        cnt_o    = cnt_q;
        active_o = (st_q == S_RESET);
        held_o   = (st_q == S_HOLD);
    end
endmodule

// File: rtl/srst_tap_dec.sv
// Decodes chain position into staggered tap outputs of equal width.
module srst_tap_dec #(
    parameter int unsigned TAPS = 7,
    parameter int unsigned DLY  = 3,
    parameter int unsigned CW   = 6
) (
    input  logic            active_i,
    input  logic            held_i,
    input  logic [CW-1:0]   cnt_i,
    output logic [TAPS-1:0] tap_o
);
    localparam int unsigned SPAN = (TAPS - 1) * DLY;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic [CW-1:0] HI = CW'(k * DLY + SPAN);
        if (k == 0) begin : g_first
            assign tap_o[k] = held_i | (active_i && cnt_i <= HI);
        end else begin : g_later
            localparam logic [CW-1:0] LO = CW'(k * DLY);
            assign tap_o[k] = held_i | (active_i && cnt_i >= LO && cnt_i <= HI);
        end
    end
endmodule

// File: rtl/srst_guard.sv
// Token admission: ready indication and sticky launch-during-reset flag.
module srst_guard
    import srst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch_i,
    input  chain_st_e main_st_i,
    input  chain_st_e sum_st_i,
    output logic      ready_o,
    output logic      err_o
);
    logic err_q;
    logic in_reset;

    always_comb begin
        in_reset = (main_st_i == S_RESET) || (main_st_i == S_SETTLE) ||
                   (main_st_i == S_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (launch_i & in_reset);
    end

    assign ready_o = (main_st_i == S_STANDBY) && (sum_st_i == S_STANDBY);
    assign err_o   = err_q;
endmodule

// File: rtl/srst_seq_top.sv
module srst_seq_top
    import srst_pkg::*;
#(
    parameter int unsigned ROWS     = 7,
    parameter int unsigned ROW_DLY  = 3,
    parameter int unsigned MON_W    = 16,
    parameter int unsigned SUM_W    = 8,
    parameter int unsigned SUM_TAPS = 3,
    parameter int unsigned SUM_DLY  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch_i,
    input  logic [MON_W-1:0]    mon_i,
    input  logic [SUM_W-1:0]    sum_t_i,
    input  logic [SUM_W-1:0]    sum_c_i,
    input  logic                tm_eval_i,
    input  logic                tm_hold_i,
    input  logic                tm_static_i,
    output logic [ROWS-1:0]     row_rst_o,
    output logic [SUM_TAPS-1:0] sum_rst_o,
    output logic                ready_o,
    output logic                err_o
);
    localparam int unsigned ROW_CW = cnt_w(2 * (ROWS - 1) * ROW_DLY);
    localparam int unsigned SUM_CW = cnt_w(2 * (SUM_TAPS - 1) * SUM_DLY);

    logic              main_done, sum_done;
    chain_st_e         main_st, sum_st;
    logic [ROW_CW-1:0] main_cnt;
    logic [SUM_CW-1:0] sum_cnt;
    logic              main_act, main_held, sum_act, sum_held;

    srst_done_or #(.W(MON_W), .RAILS(1)) u_main_done (
        .rails_i (mon_i),
        .done_o  (main_done)
    );

    srst_done_or #(.W(SUM_W), .RAILS(2)) u_sum_done (
        .rails_i ({sum_c_i, sum_t_i}),
        .done_o  (sum_done)
    );

    srst_chain #(.TAPS(ROWS), .DLY(ROW_DLY), .CW(ROW_CW)) u_main_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch_i),
        .done_i    (main_done),
        .inhibit_i (tm_eval_i),
        .hold_i    (tm_hold_i),
        .static_i  (tm_static_i),
        .st_o      (main_st),
        .cnt_o     (main_cnt),
        .active_o  (main_act),
        .held_o    (main_held)
    );

    srst_chain #(.TAPS(SUM_TAPS), .DLY(SUM_DLY), .CW(SUM_CW)) u_sum_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (1'b0),
        .done_i    (sum_done),
        .inhibit_i (tm_eval_i),
        .hold_i    (tm_hold_i),
        .static_i  (tm_static_i),
        .st_o      (sum_st),
        .cnt_o     (sum_cnt),
        .active_o  (sum_act),
        .held_o    (sum_held)
    );

    srst_tap_dec #(.TAPS(ROWS), .DLY(ROW_DLY), .CW(ROW_CW)) u_main_taps (
        .active_i (main_act),
        .held_i   (main_held),
        .cnt_i    (main_cnt),
        .tap_o    (row_rst_o)
    );

    srst_tap_dec #(.TAPS(SUM_TAPS), .DLY(SUM_DLY), .CW(SUM_CW)) u_sum_taps (
        .active_i (sum_act),
        .held_i   (sum_held),
        .cnt_i    (sum_cnt),
        .tap_o    (sum_rst_o)
    );

    srst_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch_i),
        .main_st_i (main_st),
        .sum_st_i  (sum_st),
        .ready_o   (ready_o),
        .err_o     (err_o)
    );
endmodule

// File: rtl/srst_seq_chk.sv
module srst_seq_chk #(
    parameter int unsigned ROWS     = 7,
    parameter int unsigned SUM_TAPS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                launch_i,
    input logic                tm_eval_i,
    input logic                tm_hold_i,
    input logic                tm_static_i,
    input logic [ROWS-1:0]     row_rst_o,
    input logic [SUM_TAPS-1:0] sum_rst_o,
    input logic                ready_o,
    input logic                err_o
);
    AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        tm_hold_i |=> (&row_rst_o && &sum_rst_o && !ready_o)); // R7

    AST_STATIC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_static_i && !tm_hold_i) |=> (row_rst_o == '0 && sum_rst_o == '0 && ready_o)); // R8

    AST_INHIBIT_NOFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && tm_eval_i && !tm_hold_i) |=> (row_rst_o == '0 && sum_rst_o == '0)); // R6

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (row_rst_o == '0 && sum_rst_o == '0)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(launch_i)); // R10

    for (genvar k = 1; k < ROWS; k++) begin : g_order
        AST_TAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(row_rst_o[k]) && !$past(tm_hold_i)) |-> row_rst_o[k-1]); // R3
    end
endmodule

bind srst_seq_top srst_seq_chk #(.ROWS(ROWS), .SUM_TAPS(SUM_TAPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch_i),
    .tm_eval_i   (tm_eval_i),
    .tm_hold_i   (tm_hold_i),
    .tm_static_i (tm_static_i),
    .row_rst_o   (row_rst_o),
    .sum_rst_o   (sum_rst_o),
    .ready_o     (ready_o),
    .err_o       (err_o)
);

// File: tb/sim_srst_seq_top.sv
`timescale 1ns/1ps
module sim_srst_seq_top;
    localparam int ROWS = 4, ROW_DLY = 2, MON_W = 6, SUM_W = 4, SUM_TAPS = 2, SUM_DLY = 1;
    localparam int SPAN = (ROWS - 1) * ROW_DLY;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                launch_i = 1'b0;
    logic [MON_W-1:0]    mon_i = '0;
    logic [SUM_W-1:0]    sum_t_i = '0, sum_c_i = '0;
    logic                tm_eval_i = 1'b0, tm_hold_i = 1'b0, tm_static_i = 1'b0;
    logic [ROWS-1:0]     row_rst_o;
    logic [SUM_TAPS-1:0] sum_rst_o;
    logic                ready_o, err_o;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    srst_seq_top #(.ROWS(ROWS), .ROW_DLY(ROW_DLY), .MON_W(MON_W), .SUM_W(SUM_W),
                   .SUM_TAPS(SUM_TAPS), .SUM_DLY(SUM_DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .mon_i(mon_i),
        .sum_t_i(sum_t_i), .sum_c_i(sum_c_i), .tm_eval_i(tm_eval_i),
        .tm_hold_i(tm_hold_i), .tm_static_i(tm_static_i), .row_rst_o(row_rst_o),
        .sum_rst_o(sum_rst_o), .ready_o(ready_o), .err_o(err_o));

    typedef struct packed {
        logic       launch;
        logic [5:0] mon;
        logic [3:0] st;
        logic [3:0] sc;
        logic       ev, hd, sta;
        logic [3:0] erow;
        logic [1:0] esum;
        logic       erdy, eerr;
    } vec_t;

    localparam vec_t TBL [16] = '{
        '{1'b0, 6'h00, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b01, 1'b0, 1'b0}, // sum true rail fires
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b11, 1'b0, 1'b0},
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b10, 1'b0, 1'b0},
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b00, 1'b1, 1'b0}, // END_CLEAN
        '{1'b0, 6'h00, 4'h0, 4'h4, 1'b0, 1'b0, 1'b0, 4'h0, 2'b01, 1'b0, 1'b0}, // complement rail fires
        '{1'b0, 6'h00, 4'h0, 4'h4, 1'b0, 1'b0, 1'b0, 4'h0, 2'b11, 1'b0, 1'b0},
        '{1'b0, 6'h00, 4'h0, 4'h4, 1'b0, 1'b0, 1'b0, 4'h0, 2'b10, 1'b0, 1'b0},
        '{1'b0, 6'h00, 4'h0, 4'h4, 1'b0, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0, 1'b0}, // END_BUSY
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b00, 1'b1, 1'b0}, // DRAIN
        '{1'b0, 6'h20, 4'h8, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0, 2'b00, 1'b1, 1'b0}, // static
        '{1'b1, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0, 2'b00, 1'b1, 1'b0}, // static launch
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b00, 1'b1, 1'b0},
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 4'hF, 2'b11, 1'b0, 1'b0}, // hold
        '{1'b1, 6'h00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 4'hF, 2'b11, 1'b0, 1'b1}, // launch in hold
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0, 1'b1}, // RELEASE
        '{1'b0, 6'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 2'b00, 1'b1, 1'b1}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [ROWS-1:0] exp_row(input int c);
        logic [ROWS-1:0] r;
        for (int k = 0; k < ROWS; k++)
            r[k] = (c >= k * ROW_DLY) && (c <= k * ROW_DLY + SPAN);
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        launch_i = 0; mon_i = '0; sum_t_i = '0; sum_c_i = '0;
        tm_eval_i = 0; tm_hold_i = 0; tm_static_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 row resets after reset", 32'(row_rst_o), 0);
        chk("R1 sum resets after reset", 32'(sum_rst_o), 0);
        chk("R1 ready after reset", 32'(ready_o), 1);
        chk("R1 err cleared by reset", 32'(err_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();

        // Vector table: sum chain (R5, R4), static (R8), hold (R7), error (R10)
        for (int i = 0; i < 16; i++) begin
            launch_i = TBL[i].launch; mon_i = TBL[i].mon;
            sum_t_i = TBL[i].st; sum_c_i = TBL[i].sc;
            tm_eval_i = TBL[i].ev; tm_hold_i = TBL[i].hd; tm_static_i = TBL[i].sta;
            @(negedge clk);
            chk($sformatf("R3 R7 R8 row taps vec %0d", i), 32'(row_rst_o), 32'(TBL[i].erow));
            chk($sformatf("R5 R4 sum taps vec %0d", i), 32'(sum_rst_o), 32'(TBL[i].esum));
            chk($sformatf("R9 ready vec %0d", i), 32'(ready_o), 32'(TBL[i].erdy));
            chk($sformatf("R10 err vec %0d", i), 32'(err_o), 32'(TBL[i].eerr));
        end

        // Re-reset clears sticky error (R1, R10)
        do_reset();

        // R2: launch enters EVAL
        launch_i = 1; @(negedge clk); launch_i = 0;
        chk("R2 ready low in EVAL", 32'(ready_o), 0);
        chk("R2 no resets in EVAL", 32'(row_rst_o), 0);
        @(negedge clk);
        chk("R2 EVAL holds without completion", 32'(ready_o), 0);

        // R3: main chain, cycle by cycle
        mon_i = 6'h04; @(negedge clk); mon_i = '0;
        chk("R3 tap pattern c=0", 32'(row_rst_o), 32'(exp_row(0)));
        for (int c = 1; c <= 2 * SPAN; c++) begin
            @(negedge clk);
            chk($sformatf("R3 tap pattern c=%0d", c), 32'(row_rst_o), 32'(exp_row(c)));
        end
        @(negedge clk);
        chk("R4 END_CLEAN resets low", 32'(row_rst_o), 0);
        chk("R4 END_CLEAN ready", 32'(ready_o), 1);
        chk("R10 no err for legal launch", 32'(err_o), 0);

        // R6: inhibit freezes evaluation
        launch_i = 1; @(negedge clk); launch_i = 0;
        tm_eval_i = 1; mon_i = 6'h01;
        repeat (3) begin
            @(negedge clk);
            chk("R6 inhibit keeps rows quiet", 32'(row_rst_o), 0);
            chk("R6 inhibit keeps ready low", 32'(ready_o), 0);
        end
        tm_eval_i = 0;
        @(negedge clk);
        chk("R3 fire after inhibit release", 32'(row_rst_o), 32'(exp_row(0)));
        for (int c = 1; c <= 2 * SPAN; c++) @(negedge clk);
        chk("R3 last tap alone at end", 32'(row_rst_o), 32'(exp_row(2 * SPAN)));
        @(negedge clk);
        chk("R4 END_BUSY resets low", 32'(row_rst_o), 0);
        chk("R4 END_BUSY ready low", 32'(ready_o), 0);
        @(negedge clk);
        chk("R4 SETTLE persists", 32'(ready_o), 0);
        mon_i = '0;
        @(negedge clk);
        chk("R4 DRAIN to standby", 32'(ready_o), 1);

        // R10: launch during RESET
        mon_i = 6'h10; @(negedge clk); mon_i = '0;
        @(negedge clk);
        launch_i = 1; @(negedge clk); launch_i = 0;
        chk("R10 err on launch in RESET", 32'(err_o), 1);
        for (int c = 0; c < 2 * SPAN + 2; c++) @(negedge clk);
        chk("R10 err stays set", 32'(err_o), 1);
        chk("R9 ready after chain", 32'(ready_o), 1);

        summary();
    end
endmodule